// File: doc/BRIEF.md
# Cross-Fault Matrix Builder

During memory self-test a redundancy analyser keeps a set of pivot faults: faults whose row and whose column are each unique among the pivots. The set can hold at most one pivot per available spare line, so there are at most K = row spares + column spares pivots. Every other fault is parked in a compact overflow area that belongs to the pivot it touches. A row area holds the column addresses of faults on that pivot's row. A column area holds the row addresses of faults on that pivot's column. Which faults end up as pivots depends on the order in which they are detected. For that reason the relation between pivots can only be worked out once the test has finished.

This block does that work. After the test-done strobe it walks every overflow slot, one slot per clock. It produces a K-by-K bit matrix that marks the pivots themselves (on the diagonal) and every fault lying on one pivot's row and another pivot's column. It also produces, per pivot, a flag for a fault that belongs to that pivot alone in the row direction, and another flag for the column direction. A repair-decision stage reads these outputs after the done pulse.

Top module: `cross_fault_matrix`

## Requirements
- R1: While reset is held and after its release, `xmat_o`, `row_tail_o`, `col_tail_o` and `done_o` are all zero.
- R2: When `start_i` is high at a clock edge while the block is idle, the matrix is reloaded at that edge with only the diagonal bits (i,i) set, for each i below `pivot_cnt_i`. Both tail flag vectors are cleared at the same edge, so results of an earlier run do not survive.
- R3: With K*(ROW_SPARES+COL_SPARES) slots, `done_o` is high for exactly one cycle. That cycle follows the edge that comes K*(ROW_SPARES+COL_SPARES) edges after the edge that accepted `start_i`.
- R4: A valid row-area slot of pivot i that holds column address c sets matrix bit (i,j) at index i*K+j whenever c equals the column of a pivot j, with j different from i. Row-area slot e of pivot i sits at index i*COL_SPARES+e of `row_area_vld_i`, with its address in field i*COL_SPARES+e of `row_area_i`.
- R5: A valid column-area slot of pivot j that holds row address r sets the same bit (i,j) whenever r equals the row of a pivot i, with i different from j. Column-area slot e of pivot j sits at index j*ROW_SPARES+e. When a fault is seen from both of its areas, it still yields the single bit (i,j).
- R6: A slot whose valid bit is low, or that belongs to a pivot at or above `pivot_cnt_i`, changes nothing. A pivot at or above `pivot_cnt_i` is never matched.
- R7: A valid slot that matches no other live pivot sets bit i of `row_tail_o` if it is in pivot i's row area. If it is in pivot i's column area it sets bit i of `col_tail_o`. A slot that does match a pivot leaves both tail vectors unchanged.
- R8: A `start_i` pulse that arrives while a scan is running is ignored and does not shift the done pulse.
- R9: After the done pulse, the outputs hold their values until the next accepted start, whatever happens on the data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Test finished; begin the scan |
| pivot_cnt_i | input | $clog2(K+1) | Number of live pivots |
| pivot_row_i | input | K*ROW_AW | Row of pivot i in field i |
| pivot_col_i | input | K*COL_AW | Column of pivot i in field i |
| row_area_i | input | K*COL_SPARES*COL_AW | Column addresses held in the pivot row areas |
| row_area_vld_i | input | K*COL_SPARES | Valid bits of the row-area slots |
| col_area_i | input | K*ROW_SPARES*ROW_AW | Row addresses held in the pivot column areas |
| col_area_vld_i | input | K*ROW_SPARES | Valid bits of the column-area slots |
| xmat_o | output | K*K | Matrix, bit (i,j) at index i*K+j |
| row_tail_o | output | K | Row-direction tail flag per pivot |
| col_tail_o | output | K | Column-direction tail flag per pivot |
| done_o | output | 1 | One-cycle pulse when the scan has finished |

## Verification
A hand-worked eight-fault layout with four pivots is used first. In it every overflow entry is a cross fault that is seen from both sides, which separates correct single-bit marking from wrong matrix orientation or wrong index order. A directed tail layout mixes an unmatched row entry, an unmatched column entry, an invalid slot that holds a cross address, and a valid slot of a pivot beyond the live count. This shows whether tails go in the right direction and whether masked slots are really ignored. Seeded random layouts then vary the pivot count from zero to K, with addresses that either copy a pivot coordinate or are arbitrary. Some of these runs also carry a stray start pulse mid-scan or scramble the inputs after done, which exposes timing slips and outputs that fail to hold.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_SCAN = 2'd1,
    XS_DONE = 2'd2
  } xfm_state_e;

  typedef enum logic {
    AR_ROW = 1'b0,
    AR_COL = 1'b1
  } xfm_area_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/xfm_seq.sv
module xfm_seq
  import xfm_pkg::*;
#(
  parameter int unsigned K  = 4,
  parameter int unsigned RS = 2,
  parameter int unsigned CS = 2,
  parameter int unsigned PW = 2,
  parameter int unsigned EW = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            load_o,
  output logic            step_o,
  output logic            done_o,
  output xfm_area_e       area_o,
  output logic [PW-1:0]   piv_o,
  output logic [EW-1:0]   ent_o
);

  localparam int unsigned NSLOT = K * (RS + CS);
  localparam int unsigned RW    = $clog2(NSLOT + 1);
  localparam logic [EW-1:0] ROW_ENT_LAST = EW'(CS - 1);
  localparam logic [EW-1:0] COL_ENT_LAST = EW'(RS - 1);
  localparam logic [PW-1:0] PIV_LAST     = PW'(K - 1);

  xfm_state_e      state_q;
  xfm_area_e       area_q;
  logic [PW-1:0]   piv_q;
  logic [EW-1:0]   ent_q;
  logic            ent_last;

  assign load_o = (state_q == XS_IDLE) && start_i;
  assign step_o = (state_q == XS_SCAN);
  assign done_o = (state_q == XS_DONE);
  assign area_o = area_q;
  assign piv_o  = piv_q;
  assign ent_o  = ent_q;

  assign ent_last = (area_q == AR_ROW) ? (ent_q == ROW_ENT_LAST) : (ent_q == COL_ENT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      area_q  <= AR_ROW;
      piv_q   <= '0;
      ent_q   <= '0;
    end else begin
      case (state_q)
        XS_IDLE: begin
          if (start_i) begin
            state_q <= XS_SCAN;
            area_q  <= AR_ROW;
            piv_q   <= '0;
            ent_q   <= '0;
          end
        end
        XS_SCAN: begin
          if (ent_last) begin
            ent_q <= '0;
            if (piv_q == PIV_LAST) begin
              piv_q <= '0;
              if (area_q == AR_COL) state_q <= XS_DONE;
              else                  area_q  <= AR_COL;
            end else begin
              piv_q <= piv_q + PW'(1);
            end
          end else begin
            ent_q <= ent_q + EW'(1);
          end
        end
        XS_DONE: state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  // independent scan-length counter for the checks below
  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (load_o) run_q <= '0;
    else if (step_o) run_q <= run_q + RW'(1);
  end

  p_done_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_q == RW'(NSLOT));

  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_scan_origin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> step_o && piv_o == '0 && ent_o == '0 && area_o == AR_ROW);

endmodule

// File: rtl/xfm_match.sv
module xfm_match
  import xfm_pkg::*;
#(
  parameter int unsigned K   = 4,
  parameter int unsigned RAW = 3,
  parameter int unsigned CAW = 3,
  parameter int unsigned PW  = 2,
  parameter int unsigned CW  = 3
) (
  input  xfm_area_e        area_i,
  input  logic [PW-1:0]    piv_i,
  input  logic [CAW-1:0]   slot_col_i,
  input  logic [RAW-1:0]   slot_row_i,
  input  logic [K*RAW-1:0] pivot_row_i,
  input  logic [K*CAW-1:0] pivot_col_i,
  input  logic [CW-1:0]    pivot_cnt_i,
  output logic [K-1:0]     hit_o
);

  for (genvar j = 0; j < K; j++) begin : g_cmp
    localparam logic [CW-1:0] JC = CW'(j);
    localparam logic [PW-1:0] JP = PW'(j);
    logic eq;
    assign eq = (area_i == AR_ROW) ? (slot_col_i == pivot_col_i[j*CAW +: CAW])
                                   : (slot_row_i == pivot_row_i[j*RAW +: RAW]);
    assign hit_o[j] = (JC < pivot_cnt_i) && (piv_i != JP) && eq;
  end

endmodule

// File: rtl/xfm_matrix.sv
module xfm_matrix
  import xfm_pkg::*;
#(
  parameter int unsigned K  = 4,
  parameter int unsigned PW = 2,
  parameter int unsigned CW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             slot_vld_i,
  input  xfm_area_e        area_i,
  input  logic [PW-1:0]    piv_i,
  input  logic [K-1:0]     hit_i,
  input  logic [CW-1:0]    pivot_cnt_i,
  output logic [K*K-1:0]   xmat_o,
  output logic [K-1:0]     row_tail_o,
  output logic [K-1:0]     col_tail_o
);

  function automatic logic [K*K-1:0] diag_mask();
    logic [K*K-1:0] m;
    m = '0;
    for (int a = 0; a < K; a++) m[a*K+a] = 1'b1;
    return m;
  endfunction

  localparam logic [K*K-1:0] DIAG_MASK = diag_mask();

  logic [K*K-1:0] xmat_q, diag_init, set_v;
  logic [K-1:0]   rtail_q, ctail_q, piv_oh;
  logic           active, miss;

  assign active = step_i && slot_vld_i;
  assign miss   = active && (hit_i == '0);

  for (genvar a = 0; a < K; a++) begin : g_row
    assign piv_oh[a] = (piv_i == PW'(a));
    for (genvar b = 0; b < K; b++) begin : g_col
      if (a == b) begin : g_diag
        assign diag_init[a*K+b] = (CW'(a) < pivot_cnt_i);
      end else begin : g_off
        assign diag_init[a*K+b] = 1'b0;
      end
      // row area of pivot a meets column of b, or column area of b meets row of a
      assign set_v[a*K+b] = active &&
        (((area_i == AR_ROW) && piv_oh[a] && hit_i[b]) ||
         ((area_i == AR_COL) && piv_oh[b] && hit_i[a]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xmat_q  <= '0;
      rtail_q <= '0;
      ctail_q <= '0;
    end else if (load_i) begin
      xmat_q  <= diag_init;
      rtail_q <= '0;
      ctail_q <= '0;
    end else begin
      xmat_q <= xmat_q | set_v;
      if (miss && area_i == AR_ROW) rtail_q <= rtail_q | piv_oh;
      if (miss && area_i == AR_COL) ctail_q <= ctail_q | piv_oh;
    end
  end

  assign xmat_o     = xmat_q;
  assign row_tail_o = rtail_q;
  assign col_tail_o = ctail_q;

  p_load_diag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (xmat_q & ~DIAG_MASK) == '0 && rtail_q == '0 && ctail_q == '0);

  p_diag_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ((xmat_q ^ $past(xmat_q)) & DIAG_MASK) == '0);

  p_no_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> ($past(xmat_q) & ~xmat_q) == '0);

  p_tail_only_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && slot_vld_i && hit_i != '0) |=> $stable(rtail_q) && $stable(ctail_q));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(xmat_q) && $stable(rtail_q) && $stable(ctail_q));

endmodule

// File: rtl/cross_fault_matrix.sv
module cross_fault_matrix
  import xfm_pkg::*;
#(
  parameter int unsigned ROW_SPARES = 2,
  parameter int unsigned COL_SPARES = 2,
  parameter int unsigned ROW_AW     = 3,
  parameter int unsigned COL_AW     = 3,
  localparam int unsigned K   = ROW_SPARES + COL_SPARES,
  localparam int unsigned CW  = $clog2(K + 1),
  localparam int unsigned NRS = K * COL_SPARES,
  localparam int unsigned NCS = K * ROW_SPARES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CW-1:0]         pivot_cnt_i,
  input  logic [K*ROW_AW-1:0]   pivot_row_i,
  input  logic [K*COL_AW-1:0]   pivot_col_i,
  input  logic [NRS*COL_AW-1:0] row_area_i,
  input  logic [NRS-1:0]        row_area_vld_i,
  input  logic [NCS*ROW_AW-1:0] col_area_i,
  input  logic [NCS-1:0]        col_area_vld_i,
  output logic [K*K-1:0]        xmat_o,
  output logic [K-1:0]          row_tail_o,
  output logic [K-1:0]          col_tail_o,
  output logic                  done_o
);

  localparam int unsigned PW  = clog2_min1(K);
  localparam int unsigned EW  = clog2_min1((ROW_SPARES > COL_SPARES) ? ROW_SPARES : COL_SPARES);
  localparam int unsigned RIW = clog2_min1(NRS);
  localparam int unsigned CIW = clog2_min1(NCS);

  logic            load, step, slot_live, slot_vld;
  xfm_area_e       area;
  logic [PW-1:0]   piv;
  logic [EW-1:0]   ent;
  logic [RIW-1:0]  ridx;
  logic [CIW-1:0]  cidx;
  logic [COL_AW-1:0] slot_col;
  logic [ROW_AW-1:0] slot_row;
  logic [K-1:0]    hit;

  logic [COL_AW-1:0] ra_arr [NRS];
  logic [ROW_AW-1:0] ca_arr [NCS];

  for (genvar s = 0; s < NRS; s++) begin : g_ra
    assign ra_arr[s] = row_area_i[s*COL_AW +: COL_AW];
  end
  for (genvar s = 0; s < NCS; s++) begin : g_ca
    assign ca_arr[s] = col_area_i[s*ROW_AW +: ROW_AW];
  end

  xfm_seq #(
    .K(K), .RS(ROW_SPARES), .CS(COL_SPARES), .PW(PW), .EW(EW)
  ) seq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .done_o (done_o),
    .area_o (area),
    .piv_o  (piv),
    .ent_o  (ent)
  );

  assign ridx = RIW'(piv) * RIW'(COL_SPARES) + RIW'(ent);
  assign cidx = CIW'(piv) * CIW'(ROW_SPARES) + CIW'(ent);

  assign slot_col  = ra_arr[ridx];
  assign slot_row  = ca_arr[cidx];
  assign slot_live = (CW'(piv) < pivot_cnt_i);
  assign slot_vld  = slot_live &&
                     ((area == AR_ROW) ? row_area_vld_i[ridx] : col_area_vld_i[cidx]);

  xfm_match #(
    .K(K), .RAW(ROW_AW), .CAW(COL_AW), .PW(PW), .CW(CW)
  ) match_i (
    .area_i     (area),
    .piv_i      (piv),
    .slot_col_i (slot_col),
    .slot_row_i (slot_row),
    .pivot_row_i(pivot_row_i),
    .pivot_col_i(pivot_col_i),
    .pivot_cnt_i(pivot_cnt_i),
    .hit_o      (hit)
  );

  xfm_matrix #(
    .K(K), .PW(PW), .CW(CW)
  ) matrix_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .slot_vld_i (slot_vld),
    .area_i     (area),
    .piv_i      (piv),
    .hit_i      (hit),
    .pivot_cnt_i(pivot_cnt_i),
    .xmat_o     (xmat_o),
    .row_tail_o (row_tail_o),
    .col_tail_o (col_tail_o)
  );

  p_masked_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !slot_live) |=> $stable(xmat_o) && $stable(row_tail_o) && $stable(col_tail_o));

endmodule

// File: tb/cross_fault_matrix_tb_top.sv
`timescale 1ns/1ps
module cross_fault_matrix_tb_top;

  localparam int RS  = 2;
  localparam int CS  = 2;
  localparam int RAW = 3;
  localparam int CAW = 3;
  localparam int K   = RS + CS;
  localparam int CW  = $clog2(K + 1);
  localparam int NS  = K * (RS + CS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0]       cnt_f = '0;
  logic [K*RAW-1:0]    prow_f = '0;
  logic [K*CAW-1:0]    pcol_f = '0;
  logic [K*CS*CAW-1:0] ra_f = '0;
  logic [K*CS-1:0]     ra_vf = '0;
  logic [K*RS*RAW-1:0] ca_f = '0;
  logic [K*RS-1:0]     ca_vf = '0;
  logic [K*K-1:0]      xmat;
  logic [K-1:0]        rt, ct;
  logic                done;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int prow [K];
  int pcol [K];
  int raa  [K][CS];
  bit rav  [K][CS];
  int caa  [K][RS];
  bit cav  [K][RS];
  int cntm;
  logic [K*K-1:0] exp_mat;
  logic [K-1:0]   exp_rt, exp_ct;

  always #2 clk = ~clk;

  cross_fault_matrix #(
    .ROW_SPARES(RS), .COL_SPARES(CS), .ROW_AW(RAW), .COL_AW(CAW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pivot_cnt_i(cnt_f), .pivot_row_i(prow_f), .pivot_col_i(pcol_f),
    .row_area_i(ra_f), .row_area_vld_i(ra_vf),
    .col_area_i(ca_f), .col_area_vld_i(ca_vf),
    .xmat_o(xmat), .row_tail_o(rt), .col_tail_o(ct), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h want %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: got %0d want <150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic clear_model();
    cntm = 0;
    for (int i = 0; i < K; i++) begin
      prow[i] = 0; pcol[i] = 0;
      for (int e = 0; e < CS; e++) begin raa[i][e] = 0; rav[i][e] = 0; end
      for (int e = 0; e < RS; e++) begin caa[i][e] = 0; cav[i][e] = 0; end
    end
  endtask

  task automatic pack();
    cnt_f = CW'(cntm);
    for (int i = 0; i < K; i++) begin
      prow_f[i*RAW +: RAW] = RAW'(prow[i]);
      pcol_f[i*CAW +: CAW] = CAW'(pcol[i]);
      for (int e = 0; e < CS; e++) begin
        ra_f[(i*CS+e)*CAW +: CAW] = CAW'(raa[i][e]);
        ra_vf[i*CS+e] = rav[i][e];
      end
      for (int e = 0; e < RS; e++) begin
        ca_f[(i*RS+e)*RAW +: RAW] = RAW'(caa[i][e]);
        ca_vf[i*RS+e] = cav[i][e];
      end
    end
  endtask

  task automatic gen_random();
    cntm = $urandom_range(K);
    for (int i = 0; i < K; i++) begin
      bit ok;
      do begin
        prow[i] = $urandom_range((1 << RAW) - 1);
        ok = 1;
        for (int j = 0; j < i; j++) if (prow[j] == prow[i]) ok = 0;
      end while (!ok);
      do begin
        pcol[i] = $urandom_range((1 << CAW) - 1);
        ok = 1;
        for (int j = 0; j < i; j++) if (pcol[j] == pcol[i]) ok = 0;
      end while (!ok);
    end
    for (int i = 0; i < K; i++) begin
      for (int e = 0; e < CS; e++) begin
        rav[i][e] = 1'($urandom_range(1));
        raa[i][e] = ($urandom_range(2) != 0) ? pcol[$urandom_range(K - 1)]
                                             : $urandom_range((1 << CAW) - 1);
      end
      for (int e = 0; e < RS; e++) begin
        cav[i][e] = 1'($urandom_range(1));
        caa[i][e] = ($urandom_range(2) != 0) ? prow[$urandom_range(K - 1)]
                                             : $urandom_range((1 << RAW) - 1);
      end
    end
  endtask

  task automatic compute_expected();
    exp_mat = '0; exp_rt = '0; exp_ct = '0;
    for (int i = 0; i < cntm; i++) exp_mat[i*K+i] = 1'b1;
    for (int i = 0; i < cntm; i++)
      for (int e = 0; e < CS; e++)
        if (rav[i][e]) begin
          bit hit = 0;
          for (int j = 0; j < cntm; j++)
            if (j != i && raa[i][e] == pcol[j]) begin exp_mat[i*K+j] = 1'b1; hit = 1; end
          if (!hit) exp_rt[i] = 1'b1;
        end
    for (int j = 0; j < cntm; j++)
      for (int e = 0; e < RS; e++)
        if (cav[j][e]) begin
          bit hit = 0;
          for (int i = 0; i < cntm; i++)
            if (i != j && caa[j][e] == prow[i]) begin exp_mat[i*K+j] = 1'b1; hit = 1; end
          if (!hit) exp_ct[j] = 1'b1;
        end
  endtask

  // start at an edge, then check done timing (R3), optional stray start (R8)
  task automatic run_scan(input bit mid);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= NS; c++) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (c < NS) begin
        if (done) chk(mid ? "R8 early done" : "R3 early done", 32'(done), 32'd0);
      end else begin
        chk(mid ? "R8 done timing" : "R3 done timing", 32'(done), 32'd1);
      end
      if (mid && c == 4) start = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R3 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic check_results(input string tag);
    chk({tag, " R4 R5 matrix"}, 32'(xmat), 32'(exp_mat));
    chk({tag, " R7 row tails"}, 32'(rt), 32'(exp_rt));
    chk({tag, " R7 col tails"}, 32'(ct), 32'(exp_ct));
  endtask

  initial begin
    void'($urandom(32'd20517));
    clear_model();
    pack();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset matrix", 32'(xmat), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'({xmat, rt, ct}), 32'd0);

    // eight-fault layout, pivots (2,1),(5,3),(1,4),(7,7)
    clear_model();
    cntm = 4;
    prow[0] = 2; pcol[0] = 1;
    prow[1] = 5; pcol[1] = 3;
    prow[2] = 1; pcol[2] = 4;
    prow[3] = 7; pcol[3] = 7;
    raa[0][0] = 3; rav[0][0] = 1;
    raa[1][0] = 1; rav[1][0] = 1;
    raa[1][1] = 7; rav[1][1] = 1;
    raa[3][0] = 4; rav[3][0] = 1;
    caa[0][0] = 5; cav[0][0] = 1;
    caa[1][0] = 2; cav[1][0] = 1;
    caa[2][0] = 7; cav[2][0] = 1;
    caa[3][0] = 5; cav[3][0] = 1;
    pack();
    run_scan(1'b0);
    chk("R4 R5 example matrix", 32'(xmat), 32'h0000_C4B3);
    chk("R7 example no row tail", 32'(rt), 32'd0);
    chk("R7 example no col tail", 32'(ct), 32'd0);

    // tails, invalid slot, slot of dead pivot
    clear_model();
    cntm = 2;
    prow[0] = 0; pcol[0] = 0;
    prow[1] = 3; pcol[1] = 3;
    prow[2] = 6; pcol[2] = 6;
    prow[3] = 5; pcol[3] = 5;
    raa[0][0] = 6; rav[0][0] = 1;
    raa[0][1] = 3; rav[0][1] = 0;
    raa[1][0] = 0; rav[1][0] = 1;
    raa[3][0] = 0; rav[3][0] = 1;
    caa[1][0] = 5; cav[1][0] = 1;
    caa[0][1] = 6; cav[0][1] = 0;
    pack();
    run_scan(1'b0);
    chk("R6 R5 tail layout matrix", 32'(xmat), 32'h0000_0031);
    chk("R7 row tail on pivot0", 32'(rt), 32'h1);
    chk("R7 col tail on pivot1", 32'(ct), 32'h2);

    // stale results cleared by next run (R2)
    clear_model();
    cntm = 1;
    pack();
    run_scan(1'b0);
    chk("R2 stale cleared matrix", 32'(xmat), 32'h1);
    chk("R2 stale cleared tails", 32'({rt, ct}), 32'd0);

    for (int n = 0; n < 60; n++) begin
      gen_random();
      compute_expected();
      pack();
      run_scan(n % 5 == 2);
      check_results($sformatf("rand%0d", n));
      gen_random();
      pack();
      repeat (3) @(negedge clk);
      chk("R9 hold matrix", 32'(xmat), 32'(exp_mat));
      chk("R9 hold tails", 32'({rt, ct}), 32'({exp_rt, exp_ct}));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule